// File: doc/BRIEF.md
# Shift-Register Video Timing Generator

This block produces horizontal sync, vertical sync and a display-enable signal for a raster display, plus one-cycle strobes at the start of each line and each frame. It does not use binary counters. Both the horizontal and the vertical position are held in 16-bit linear feedback shift registers. These have only a few XOR gates between flops, so the counter logic stays shallow at pixel-clock rates.

Every programmed threshold is therefore an LFSR state and not a count. To make an event fire N steps after the start of a line, software loads the state the register reaches after N steps from the all-ones seed. The horizontal register steps on every enabled pixel clock. The vertical register steps once for each horizontal wrap. Lines and frames begin at the sync pulse, so the active window sits at an offset of (total - sync start) into the line or frame.

A power-down input blanks the sync and enable outputs while the counters keep running. Pixel fetch, clock generation and register programming are outside this block. The threshold inputs are assumed to hold committed values.

Top module: `vtg_lfsr_timing`

## Requirements
- R1: While rst_ni is low, every output is 0. Both position registers restart from the seed 16'hFFFF, which is position index 0.
- R2: One step maps state s to {s[14:0], s[15]^s[4]^s[2]^s[1]}. A threshold for index N is the state reached after N steps from 16'hFFFF. With the horizontal end threshold set to index H, a line lasts H+1 enabled cycles.
- R3: When en_i is high and the horizontal register equals h_end_i, the register returns to the seed on the next edge. On that edge line_start_o goes high for one cycle.
- R4: The vertical register steps only on a horizontal wrap, and it returns to the seed on a wrap that occurs while it equals v_end_i. frame_start_o pulses together with the line_start_o of that wrap.
- R5: hsync_o rises on the edge after an enabled cycle in which the horizontal register equals h_sync_on_i. It falls on the edge after one in which it equals h_sync_off_i. When both thresholds are equal, the rise wins.
- R6: vsync_o follows the same set/clear rule against the vertical register, using v_sync_on_i and v_sync_off_i.
- R7: de_o is the AND of a horizontal-active flag and a vertical-active flag. The horizontal flag is set/cleared by h_act_on_i/h_act_off_i and the vertical flag by v_act_on_i/v_act_off_i, with the same rule as R5. A threshold that the position register never reaches leaves its flag unchanged.
- R8: While en_i is low, both registers and all flags hold, and line_start_o and frame_start_o are 0.
- R9: While blank_pd_i is high, hsync_o, vsync_o and de_o are 0. Counters, flags and strobes keep running, so the outputs show the current flag state as soon as blank_pd_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance timing by one pixel this cycle |
| blank_pd_i | input | 1 | Power-down blanking of sync and enable |
| h_end_i | input | 16 | Horizontal wrap state |
| h_sync_on_i | input | 16 | Horizontal state that raises hsync |
| h_sync_off_i | input | 16 | Horizontal state that lowers hsync |
| h_act_on_i | input | 16 | Horizontal state that opens the active window |
| h_act_off_i | input | 16 | Horizontal state that closes the active window |
| v_end_i | input | 16 | Vertical wrap state |
| v_sync_on_i | input | 16 | Vertical state that raises vsync |
| v_sync_off_i | input | 16 | Vertical state that lowers vsync |
| v_act_on_i | input | 16 | Vertical state that opens the active window |
| v_act_off_i | input | 16 | Vertical state that closes the active window |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| line_start_o | output | 1 | One-cycle strobe when a new line begins |
| frame_start_o | output | 1 | One-cycle strobe when a new frame begins |

## Verification
A first timing set uses a 20-pixel line and a 9-line frame, with sync, active start and active end at distinct positions. Running it across two frames separates off-by-one errors in wrap, set and clear timing, and it also exposes a wrong tap, since a wrong tap moves every threshold match. A gapped enable pattern of two on and one off shows whether the registers, the flags and the strobes all freeze together. A power-down interval shows whether blanking masks only the outputs or also stalls the timing. A second, tiny timing set has equal sync thresholds, a vertical wrap at index 3 and an active-start threshold placed beyond the end of the line. It checks the rise-wins priority, fast frame wraps, and that a threshold which is never reached has no effect.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
  // feedback taps at bits 15, 4, 2, 1
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8016;
  localparam int unsigned N_FLAGS = 4;

  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef struct packed {
    lfsr_t set_st;
    lfsr_t clr_st;
  } vtg_window_t;

  function automatic lfsr_t lfsr_next(input lfsr_t s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction
endpackage

// File: rtl/vtg_lfsr_ctr.sv
module vtg_lfsr_ctr
  import vtg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  lfsr_t end_st_i,
  output lfsr_t state_o,
  output logic  wrap_o
);
  lfsr_t state_q;

  assign wrap_o  = step_i && (state_q == end_st_i);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= LFSR_SEED;
    else if (wrap_o) state_q <= LFSR_SEED;
    else if (step_i) state_q <= lfsr_next(state_q);
  end

  // a seeded LFSR of this form can never reach the all-zero lock-up state
  p_never_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
endmodule

// File: rtl/vtg_window_flag.sv
module vtg_window_flag
  import vtg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        upd_i,
  input  lfsr_t       pos_i,
  input  vtg_window_t win_i,
  output logic        flag_o
);
  logic flag_q;
  logic hit_set, hit_clr;

  assign hit_set = upd_i && (pos_i == win_i.set_st);
  assign hit_clr = upd_i && (pos_i == win_i.clr_st);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (hit_set) flag_q <= 1'b1;
    else if (hit_clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_rise_on_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(pos_i) == $past(win_i.set_st)));

  p_frozen_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flag_q));
endmodule

// File: rtl/vtg_lfsr_timing.sv
module vtg_lfsr_timing
  import vtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              blank_pd_i,
  input  logic [LFSR_W-1:0] h_end_i,
  input  logic [LFSR_W-1:0] h_sync_on_i,
  input  logic [LFSR_W-1:0] h_sync_off_i,
  input  logic [LFSR_W-1:0] h_act_on_i,
  input  logic [LFSR_W-1:0] h_act_off_i,
  input  logic [LFSR_W-1:0] v_end_i,
  input  logic [LFSR_W-1:0] v_sync_on_i,
  input  logic [LFSR_W-1:0] v_sync_off_i,
  input  logic [LFSR_W-1:0] v_act_on_i,
  input  logic [LFSR_W-1:0] v_act_off_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              line_start_o,
  output logic              frame_start_o
);
  // flag slots: 0 hsync, 1 h-active (horizontal), 2 vsync, 3 v-active (vertical)
  localparam int unsigned F_HS = 0;
  localparam int unsigned F_HA = 1;
  localparam int unsigned F_VS = 2;
  localparam int unsigned F_VA = 3;
  localparam int unsigned N_H  = 2;

  lfsr_t       h_pos, v_pos;
  logic        h_wrap, v_wrap;
  vtg_window_t win [N_FLAGS];
  logic [N_FLAGS-1:0] flag;
  logic        ls_q, fs_q;

  vtg_lfsr_ctr u_h_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (en_i),
    .end_st_i (h_end_i),
    .state_o  (h_pos),
    .wrap_o   (h_wrap)
  );

  vtg_lfsr_ctr u_v_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (h_wrap),
    .end_st_i (v_end_i),
    .state_o  (v_pos),
    .wrap_o   (v_wrap)
  );

  assign win[F_HS] = '{set_st: h_sync_on_i, clr_st: h_sync_off_i};
  assign win[F_HA] = '{set_st: h_act_on_i,  clr_st: h_act_off_i};
  assign win[F_VS] = '{set_st: v_sync_on_i, clr_st: v_sync_off_i};
  assign win[F_VA] = '{set_st: v_act_on_i,  clr_st: v_act_off_i};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    lfsr_t pos_sel;
    if (g < N_H) begin : g_h
      assign pos_sel = h_pos;
    end else begin : g_v
      assign pos_sel = v_pos;
    end
    vtg_window_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (en_i),
      .pos_i  (pos_sel),
      .win_i  (win[g]),
      .flag_o (flag[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ls_q <= 1'b0;
      fs_q <= 1'b0;
    end else begin
      ls_q <= h_wrap;
      fs_q <= v_wrap;
    end
  end

  assign line_start_o  = ls_q;
  assign frame_start_o = fs_q;
  assign hsync_o = flag[F_HS] & ~blank_pd_i;
  assign vsync_o = flag[F_VS] & ~blank_pd_i;
  assign de_o    = flag[F_HA] & flag[F_VA] & ~blank_pd_i;

  p_frame_in_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o);

  p_v_moves_at_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(v_pos) |-> line_start_o);

  p_pd_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_pd_i |-> !(hsync_o || vsync_o || de_o));
endmodule

// File: tb/vtg_lfsr_timing_tb.sv
`timescale 1ns/1ps
module vtg_lfsr_timing_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, pd = 1'b0;
  logic [15:0] h_end, h_son, h_soff, h_aon, h_aoff;
  logic [15:0] v_end, v_son, v_soff, v_aon, v_aoff;
  logic hsync, vsync, de, ls, fs;

  int checks = 0, failures = 0;
  bit done = 0, run_chk = 0;

  // programmed indices used by the model
  int HE, HSN, HSF, HAN, HAF, VE, VSN, VSF, VAN, VAF;
  // model state
  int hi, vi;
  bit m_hs, m_ha, m_vs, m_va, m_ls, m_fs;

  always #2 clk = ~clk;

  vtg_lfsr_timing dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .blank_pd_i(pd),
    .h_end_i(h_end), .h_sync_on_i(h_son), .h_sync_off_i(h_soff),
    .h_act_on_i(h_aon), .h_act_off_i(h_aoff),
    .v_end_i(v_end), .v_sync_on_i(v_son), .v_sync_off_i(v_soff),
    .v_act_on_i(v_aon), .v_act_off_i(v_aoff),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .line_start_o(ls), .frame_start_o(fs)
  );

  function automatic logic [15:0] enc(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic cfg(input int he, hsn, hsf, han, haf, ve, vsn, vsf, van, vaf);
    HE = he; HSN = hsn; HSF = hsf; HAN = han; HAF = haf;
    VE = ve; VSN = vsn; VSF = vsf; VAN = van; VAF = vaf;
    h_end = enc(he); h_son = enc(hsn); h_soff = enc(hsf);
    h_aon = enc(han); h_aoff = enc(haf);
    v_end = enc(ve); v_son = enc(vsn); v_soff = enc(vsf);
    v_aon = enc(van); v_aoff = enc(vaf);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // behavioural reference: integer positions, set-wins flags
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi = 0; vi = 0;
      m_hs = 0; m_ha = 0; m_vs = 0; m_va = 0; m_ls = 0; m_fs = 0;
    end else if (en) begin
      bit wr;
      wr = (hi == HE);
      if (hi == HSN) m_hs = 1; else if (hi == HSF) m_hs = 0;
      if (hi == HAN) m_ha = 1; else if (hi == HAF) m_ha = 0;
      if (vi == VSN) m_vs = 1; else if (vi == VSF) m_vs = 0;
      if (vi == VAN) m_va = 1; else if (vi == VAF) m_va = 0;
      m_ls = wr;
      m_fs = wr && (vi == VE);
      if (wr) begin
        hi = 0;
        vi = (vi == VE) ? 0 : vi + 1;
      end else hi = hi + 1;
    end else begin
      m_ls = 0; m_fs = 0;
    end
  end

  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      chk(pd ? "R9 hsync" : "R5 hsync", hsync, m_hs && !pd);
      chk(pd ? "R9 vsync" : "R6 vsync", vsync, m_vs && !pd);
      chk(pd ? "R9 de"    : "R7 de",    de,    m_ha && m_va && !pd);
      chk(en ? "R3 line_start"  : "R8 line_start",  ls, m_ls);
      chk(en ? "R4 frame_start" : "R8 frame_start", fs, m_fs);
    end
  end

  initial begin
    cfg(19, 1, 4, 5, 17, 8, 0, 2, 3, 7);
    tick(3);
    @(negedge clk);
    chk("R1 hsync", hsync, 1'b0); chk("R1 vsync", vsync, 1'b0);
    chk("R1 de", de, 1'b0); chk("R1 line_start", ls, 1'b0);
    chk("R1 frame_start", fs, 1'b0);
    #1 rst_n = 1'b1;
    run_chk = 1;
    tick(1);
    en = 1'b1;
    tick(400);
    begin : r2_period
      int cnt;
      cnt = 0;
      @(negedge clk);
      while (!ls) @(negedge clk);
      @(negedge clk);
      cnt = 1;
      while (!ls) begin cnt++; @(negedge clk); end
      chk("R2 line period is 20", cnt == 20, 1'b1);
      if (cnt != 20) $display("FAIL R2 period actual=%0d expected=20", cnt);
    end
    tick(1);
    for (int k = 0; k < 240; k++) begin
      en = (k % 3) != 0;
      tick(1);
    end
    en = 1'b1;
    pd = 1'b1;
    tick(120);
    pd = 1'b0;
    tick(120);
    // second timing: equal sync thresholds, unreachable active start
    run_chk = 0;
    rst_n = 1'b0;
    en = 1'b0;
    cfg(6, 1, 1, 40, 5, 3, 0, 1, 1, 3);
    tick(2);
    rst_n = 1'b1;
    run_chk = 1;
    en = 1'b1;
    tick(200);
    en = 1'b0;
    tick(10);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule